// File: doc/BRIEF.md
# Eight-Bit Arithmetic, Logic and Shift Unit with Status Flags

This block is the data-path engine of a small processor core. Each cycle it can accept one operation: a destination operand, a source operand (the caller routes an immediate onto the same input), the present status flags, and a five-bit operation code. One clock later it returns the result and a new flag vector. The register file and the status-flag storage belong to the caller. The caller writes `result` back to the destination register and `flags_out` back to the status storage.

The unit covers addition and subtraction with and without an incoming carry, increment, decrement, negation, AND, OR, XOR, one's complement, logical and arithmetic shifts, rotation through carry, and exchange of the two halves of the operand. Each operation has its own set of flags that it is allowed to change. Every flag outside that set is copied unchanged from `flags_in`, so the caller can always write back the whole vector.

The operand width is a parameter with a default of 8. The half-carry flag comes from the boundary between the lower and upper halves of the operand, which is bit 3 at the default width.

Top module: `byte_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `result` and `flags_out` go to zero. Otherwise `out_valid` one cycle later equals `in_valid`, and an accepted operation appears on `result`/`flags_out` one clock after `in_valid` was high.
- R2: Op codes 0 (add) and 1 (add with carry) give d + s (+ C for code 1). C is the carry out of the top bit, H is the carry out of the lower half, and V is two's-complement overflow. All six flags are written.
- R3: Op codes 2 (subtract) and 3 (subtract with carry) give d − s (− C for code 3). C is set on an unsigned borrow, H on a borrow from the lower half, and V on signed overflow. All six flags are written.
- R4: Op codes 4 (increment) and 5 (decrement) give d ± 1. V is set only when the signed range is crossed. C and H are copied from `flags_in`.
- R5: Op code 6 (negate) gives 0 − d. Its flags follow subtraction from zero: C = (d ≠ 0), H = (lower half of d ≠ 0), and V is set only when d is the most negative value.
- R6: Op codes 7, 8 and 9 (AND, OR, XOR) clear V, write S, N and Z, and copy C and H from `flags_in`.
- R7: Op code 10 (one's complement) gives the bitwise inverse of d. It sets C, clears V, writes S, N and Z, and keeps H.
- R8: Op codes 11 (shift left, zero fill) and 14 (rotate left through C) move the old top bit into C. Code 11 fills bit 0 with zero and code 14 fills it with the old C. H takes the old top bit of the lower half, and V = N xor C.
- R9: Op codes 12 (logical right), 13 (arithmetic right, top bit kept) and 15 (rotate right through C, old C into the top bit) move the old bit 0 into C. V = N xor C, and H is kept.
- R10: Op code 16 exchanges the upper and lower halves of d and passes every flag through unchanged.
- R11: For every flag-writing operation, N is the top result bit, Z is set exactly when the result is zero, and S = N xor V.
- R12: Op codes 17 to 31 are reserved. They return d unchanged and pass every flag through.
- R13: A cycle with `in_valid` low leaves `result` and `flags_out` unchanged, whatever the data inputs carry.
- R14: The flag vector is ordered bit 5 H, bit 4 S, bit 3 V, bit 2 N, bit 1 Z, bit 0 C. Carry-in for codes 1, 3, 14 and 15 is bit 0 of `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| op | input | 5 | Operation code |
| dst | input | WIDTH | Destination operand |
| src | input | WIDTH | Source operand or immediate |
| flags_in | input | 6 | Present status flags (H S V N Z C) |
| out_valid | output | 1 | Result registers were loaded by the last edge |
| result | output | WIDTH | Operation result |
| flags_out | output | 6 | Updated status flags (H S V N Z C) |

## Verification
The bench builds the unit with `WIDTH` set to 4. At that width every operand pair (256 per operation) can be applied to all seventeen defined operations and to several reserved codes, each under four different incoming flag patterns. The half-carry boundary moves to bit 1 at this width. The sweep therefore still crosses every carry, borrow, signed-overflow and zero-result edge: the most negative and most positive values, and carry-in into an all-ones operand. The same vectors show, at the ports, that C and H pass through for the operations that must not touch them. A separate idle cycle with changed inputs shows that results hold when no operation is issued.

// File: rtl/byte_alu_pkg.sv
// Package: shared operation codes, flag bit positions and per-operation
// flag-write masks for the arithmetic, logic and shift unit.
// Assumes the flag vector ordering H S V N Z C from bit 5 down to bit 0.
package byte_alu_pkg;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 6;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_INC  = 5'd4,
        OP_DEC  = 5'd5,
        OP_NEG  = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_XOR  = 5'd9,
        OP_COM  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ASR  = 5'd13,
        OP_ROL  = 5'd14,
        OP_ROR  = 5'd15,
        OP_SWAP = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_LOGIC,
        CLS_SHIFT,
        CLS_PASS
    } alu_cls_e;

    // Map an operation to the sub-unit that produces its result.
    function automatic alu_cls_e op_class(alu_op_e op);
        alu_cls_e cls;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_INC, OP_DEC, OP_NEG:          cls = CLS_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_COM:   cls = CLS_LOGIC;
            OP_LSL, OP_LSR, OP_ASR,
            OP_ROL, OP_ROR:                  cls = CLS_SHIFT;
            default:                         cls = CLS_PASS;
        endcase
        return cls;
    endfunction

    // Return the set of flags an operation is allowed to write.
    function automatic logic [FLAG_W-1:0] flag_mask(alu_op_e op);
        logic [FLAG_W-1:0] m;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_NEG, OP_LSL, OP_ROL:          m = 6'b111111;
            OP_INC, OP_DEC,
            OP_AND, OP_OR, OP_XOR:           m = 6'b011110;
            OP_COM, OP_LSR, OP_ASR, OP_ROR:  m = 6'b011111;
            default:                         m = 6'b000000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/byte_alu_arith.sv
// Adder/subtractor slice: add, add with carry, subtract, subtract with
// borrow, increment, decrement and negate on one shared adder.
// Assumes WIDTH is even; half-carry is taken at the WIDTH/2 boundary.
// Carry and half-carry outputs are in borrow sense for subtracting ops.
module byte_alu_arith
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   dst,
    input  logic [WIDTH-1:0]   src,
    input  logic               cin,
    output logic [WIDTH-1:0]   res,
    output logic               half_out,
    output logic               carry_out,
    output logic               ovf_out
);

    localparam int HALF = WIDTH / 2;
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic               is_sub;
    logic               use_cin;
    logic [WIDTH-1:0]   opa;
    logic [WIDTH-1:0]   opb;
    logic [WIDTH-1:0]   opb_eff;
    logic               cin_eff;
    logic [WIDTH:0]     full_sum;
    logic [HALF:0]      low_sum;

    // Select adder operands and the effective carry-in for the operation.
    always_comb begin
        is_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_DEC) || (op == OP_NEG);
        use_cin = (op == OP_ADC) || (op == OP_SBC);
        opa     = (op == OP_NEG) ? '0 : dst;
        case (op)
            OP_INC, OP_DEC: opb = ONE;
            OP_NEG:         opb = dst;
            default:        opb = src;
        endcase
        opb_eff = is_sub ? ~opb : opb;
        cin_eff = is_sub ? ~(use_cin & cin) : (use_cin & cin);
    end

    // Full-width and lower-half additions with carry/borrow extraction.
    always_comb begin
        full_sum  = {1'b0, opa} + {1'b0, opb_eff} + {{WIDTH{1'b0}}, cin_eff};
        low_sum   = {1'b0, opa[HALF-1:0]} + {1'b0, opb_eff[HALF-1:0]}
                  + {{HALF{1'b0}}, cin_eff};
        res       = full_sum[WIDTH-1:0];
        carry_out = full_sum[WIDTH] ^ is_sub;
        half_out  = low_sum[HALF] ^ is_sub;
        ovf_out   = (opa[WIDTH-1] == opb_eff[WIDTH-1])
                 && (full_sum[WIDTH-1] != opa[WIDTH-1]);
    end

endmodule

// File: rtl/byte_alu_logic.sv
// Bitwise slice: AND, OR, XOR, one's complement and half exchange.
// Any other code returns the destination operand unchanged.
// Assumes WIDTH is even so the two halves have equal size.
module byte_alu_logic
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   dst,
    input  logic [WIDTH-1:0]   src,
    output logic [WIDTH-1:0]   res
);

    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] swapped;

    // Cross-wire each lower-half bit with its upper-half partner.
    for (genvar i = 0; i < HALF; i++) begin : g_swap
        assign swapped[i]        = dst[i+HALF];
        assign swapped[i+HALF]   = dst[i];
    end

    // Pick the bitwise result for the operation.
    always_comb begin
        case (op)
            OP_AND:  res = dst & src;
            OP_OR:   res = dst | src;
            OP_XOR:  res = dst ^ src;
            OP_COM:  res = ~dst;
            OP_SWAP: res = swapped;
            default: res = dst;
        endcase
    end

endmodule

// File: rtl/byte_alu_shift.sv
// Shift slice: logical left/right, arithmetic right, and rotates through
// the carry flag. Reports the bit shifted out and the old top bit of the
// lower half (used as half-carry by left shifts).
// Assumes WIDTH is even and at least 2.
module byte_alu_shift
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   dst,
    input  logic               cin,
    output logic [WIDTH-1:0]   res,
    output logic               carry_out,
    output logic               half_out
);

    localparam int HALF = WIDTH / 2;

    // Form the shifted value and the bit that leaves the operand.
    always_comb begin
        half_out = dst[HALF-1];
        case (op)
            OP_LSL: begin
                res       = {dst[WIDTH-2:0], 1'b0};
                carry_out = dst[WIDTH-1];
            end
            OP_ROL: begin
                res       = {dst[WIDTH-2:0], cin};
                carry_out = dst[WIDTH-1];
            end
            OP_LSR: begin
                res       = {1'b0, dst[WIDTH-1:1]};
                carry_out = dst[0];
            end
            OP_ASR: begin
                res       = {dst[WIDTH-1], dst[WIDTH-1:1]};
                carry_out = dst[0];
            end
            OP_ROR: begin
                res       = {cin, dst[WIDTH-1:1]};
                carry_out = dst[0];
            end
            default: begin
                res       = dst;
                carry_out = cin;
            end
        endcase
    end

endmodule

// File: rtl/byte_alu.sv
// Top of the arithmetic, logic and shift unit. Decodes the operation,
// runs the three slices in parallel, forms N/Z/S/V, merges new flags with
// the incoming ones under a per-operation write mask, and registers the
// result one clock after in_valid. Reset is synchronous, active low.
// Assumes WIDTH is even; flags are ordered H S V N Z C (bit 5..0).
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op,
    input  logic [WIDTH-1:0]    dst,
    input  logic [WIDTH-1:0]    src,
    input  logic [FLAG_W-1:0]   flags_in,
    output logic                out_valid,
    output logic [WIDTH-1:0]    result,
    output logic [FLAG_W-1:0]   flags_out
);

    alu_op_e            op_e;
    alu_cls_e           cls;
    logic               cin;

    logic [WIDTH-1:0]   ar_res;
    logic               ar_h;
    logic               ar_c;
    logic               ar_v;
    logic [WIDTH-1:0]   lg_res;
    logic [WIDTH-1:0]   sh_res;
    logic               sh_c;
    logic               sh_h;

    logic [WIDTH-1:0]   res_nx;
    logic               f_h;
    logic               f_c;
    logic               f_v;
    logic               f_n;
    logic               f_z;
    logic               f_s;
    logic [FLAG_W-1:0]  new_flags;
    logic [FLAG_W-1:0]  wmask;
    logic [FLAG_W-1:0]  flags_nx;

    assign op_e = alu_op_e'(op);
    assign cls  = op_class(op_e);
    assign cin  = flags_in[FL_C];

    byte_alu_arith #(.WIDTH(WIDTH)) arith_i (
        .op        (op_e),
        .dst       (dst),
        .src       (src),
        .cin       (cin),
        .res       (ar_res),
        .half_out  (ar_h),
        .carry_out (ar_c),
        .ovf_out   (ar_v)
    );

    byte_alu_logic #(.WIDTH(WIDTH)) logic_i (
        .op  (op_e),
        .dst (dst),
        .src (src),
        .res (lg_res)
    );

    byte_alu_shift #(.WIDTH(WIDTH)) shift_i (
        .op        (op_e),
        .dst       (dst),
        .cin       (cin),
        .res       (sh_res),
        .carry_out (sh_c),
        .half_out  (sh_h)
    );

    // Steer result, carry, half-carry and overflow from the active slice.
    always_comb begin
        case (cls)
            CLS_ARITH: begin
                res_nx = ar_res;
                f_c    = ar_c;
                f_h    = ar_h;
            end
            CLS_SHIFT: begin
                res_nx = sh_res;
                f_c    = sh_c;
                f_h    = sh_h;
            end
            default: begin
                res_nx = lg_res;
                f_c    = 1'b1;
                f_h    = 1'b0;
            end
        endcase
        f_n = res_nx[WIDTH-1];
        f_z = (res_nx == '0);
        case (cls)
            CLS_ARITH: f_v = ar_v;
            CLS_SHIFT: f_v = f_n ^ f_c;
            default:   f_v = 1'b0;
        endcase
        f_s = f_n ^ f_v;
    end

    // Merge freshly computed flags with the incoming ones under the mask.
    always_comb begin
        new_flags        = '0;
        new_flags[FL_H]  = f_h;
        new_flags[FL_S]  = f_s;
        new_flags[FL_V]  = f_v;
        new_flags[FL_N]  = f_n;
        new_flags[FL_Z]  = f_z;
        new_flags[FL_C]  = f_c;
        wmask            = flag_mask(op_e);
        flags_nx         = (new_flags & wmask) | (flags_in & ~wmask);
    end

    // Output register stage: load on in_valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= res_nx;
                flags_out <= flags_nx;
            end
        end
    end

endmodule

// File: rtl/byte_alu_chk.sv
// Checker for byte_alu: port-level temporal properties on flag handling,
// attached to every byte_alu instance through the bind below.
module byte_alu_chk
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [OP_W-1:0]     op,
    input logic [WIDTH-1:0]    dst,
    input logic [WIDTH-1:0]    src,
    input logic [FLAG_W-1:0]   flags_in,
    input logic                out_valid,
    input logic [WIDTH-1:0]    result,
    input logic [FLAG_W-1:0]   flags_out
);

    logic unused_src;
    assign unused_src = ^src;

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_incdec_keep_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_INC || op == OP_DEC)) |=>
        (flags_out[FL_C] == $past(flags_in[FL_C]) && flags_out[FL_H] == $past(flags_in[FL_H])));

    p_logic_clear_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=>
        (!flags_out[FL_V] && flags_out[FL_C] == $past(flags_in[FL_C])));

    p_com_sets_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_COM) |=> (flags_out[FL_C] && !flags_out[FL_V]));

    p_shift_v_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= OP_LSL && op <= OP_ROR) |=>
        (flags_out[FL_V] == (flags_out[FL_N] ^ flags_out[FL_C])));

    p_swap_keeps_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SWAP) |=> (flags_out == $past(flags_in)));

    p_sign_zero_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op < OP_SWAP) |=>
        (flags_out[FL_S] == (flags_out[FL_N] ^ flags_out[FL_V])
         && flags_out[FL_Z] == (result == '0)
         && flags_out[FL_N] == result[WIDTH-1]));

    p_reserved_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > OP_SWAP) |=>
        (result == $past(dst) && flags_out == $past(flags_in)));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out)));

endmodule

bind byte_alu byte_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .dst       (dst),
    .src       (src),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out)
);

// File: tb/byte_alu_tb_top.sv
// Exhaustive sweep of byte_alu at WIDTH=4 against an arithmetic model.
module byte_alu_tb_top;

    localparam int TW = 4;
    localparam int MW = 1 << TW;
    localparam int SG = 1 << (TW - 1);
    localparam int NB = 1 << (TW / 2);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [4:0]      op;
    logic [TW-1:0]   dst;
    logic [TW-1:0]   src;
    logic [5:0]      flags_in;
    logic            out_valid;
    logic [TW-1:0]   result;
    logic [5:0]      flags_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    byte_alu #(.WIDTH(TW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .dst       (dst),
        .src       (src),
        .flags_in  (flags_in),
        .out_valid (out_valid),
        .result    (result),
        .flags_out (flags_out)
    );

    function automatic int b2i(bit x);
        return x ? 1 : 0;
    endfunction

    function automatic int sgn(int x);
        return (x >= SG) ? x - MW : x;
    endfunction

    // Arithmetic reference model built from the requirements.
    function automatic void model(input int opc, input int d, input int s, input int fin,
                                  output int r, output int fo);
        int cin, ci, full, sr, h, v, c, n, z, sf, mask, nf;
        cin = fin & 1;
        h = 0; v = 0; c = 0; mask = 0; r = d;
        case (opc)
            0, 1: begin
                ci = (opc == 1) ? cin : 0;
                full = d + s + ci; r = full % MW;
                c = b2i(full >= MW); h = b2i((d % NB + s % NB + ci) >= NB);
                sr = sgn(d) + sgn(s) + ci; v = b2i(sr > SG - 1 || sr < -SG); mask = 63;
            end
            2, 3: begin
                ci = (opc == 3) ? cin : 0;
                full = d - s - ci; r = (full + 2 * MW) % MW;
                c = b2i(full < 0); h = b2i((d % NB - s % NB - ci) < 0);
                sr = sgn(d) - sgn(s) - ci; v = b2i(sr > SG - 1 || sr < -SG); mask = 63;
            end
            4: begin r = (d + 1) % MW; v = b2i(sgn(d) + 1 > SG - 1); mask = 30; end
            5: begin r = (d + MW - 1) % MW; v = b2i(sgn(d) - 1 < -SG); mask = 30; end
            6: begin
                r = (MW - d) % MW; c = b2i(d != 0); h = b2i((d % NB) != 0);
                v = b2i(-sgn(d) > SG - 1); mask = 63;
            end
            7:  begin r = d & s; mask = 30; end
            8:  begin r = d | s; mask = 30; end
            9:  begin r = d ^ s; mask = 30; end
            10: begin r = MW - 1 - d; c = 1; mask = 31; end
            11: begin r = (d * 2) % MW; c = b2i(d >= SG); h = (d / (NB / 2)) % 2; mask = 63; end
            12: begin r = d / 2; c = d % 2; mask = 31; end
            13: begin r = d / 2 + ((d >= SG) ? SG : 0); c = d % 2; mask = 31; end
            14: begin r = (d * 2 + cin) % MW; c = b2i(d >= SG); h = (d / (NB / 2)) % 2; mask = 63; end
            15: begin r = d / 2 + cin * SG; c = d % 2; mask = 31; end
            16: begin r = (d % NB) * NB + d / NB; mask = 0; end
            default: begin r = d; mask = 0; end
        endcase
        n = b2i(r >= SG);
        z = b2i(r == 0);
        if (opc >= 11 && opc <= 15) v = n ^ c;
        sf = n ^ v;
        nf = (h << 5) | (sf << 4) | (v << 3) | (n << 2) | (z << 1) | c;
        fo = (nf & mask) | (fin & ~mask & 63);
    endfunction

    function automatic string req_of(int opc);
        case (opc)
            0, 1:        return "R2";
            2, 3:        return "R3";
            4, 5:        return "R4";
            6:           return "R5";
            7, 8, 9:     return "R6";
            10:          return "R7";
            11, 14:      return "R8";
            12, 13, 15:  return "R9";
            16:          return "R10";
            default:     return "R12";
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(int opc, int d, int s, int fin);
        int er, ef;
        @(negedge clk);
        in_valid = 1'b1;
        op       = opc[4:0];
        dst      = d[TW-1:0];
        src      = s[TW-1:0];
        flags_in = fin[5:0];
        @(posedge clk);
        #1;
        model(opc, d, s, fin, er, ef);
        chk(req_of(opc), "result", int'(result), er);
        chk(req_of(opc), "flags (R14 order)", int'(flags_out), ef);
        if (opc < 16) begin
            chk("R11", "S=N^V", b2i(flags_out[4]), b2i(flags_out[2] ^ flags_out[3]));
            chk("R11", "Z", b2i(flags_out[1]), b2i(result == '0));
        end
    endtask

    initial begin
        int fpat[4];
        int ops[20];
        fpat[0] = 0; fpat[1] = 63; fpat[2] = 42; fpat[3] = 21;
        for (int i = 0; i < 17; i++) ops[i] = i;
        ops[17] = 17; ops[18] = 23; ops[19] = 31;

        rst_n = 1'b0; in_valid = 1'b1; op = 5'd0;
        dst = '1; src = '1; flags_in = 6'h3f;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset out_valid", b2i(out_valid), 0);
        chk("R1", "reset result", int'(result), 0);
        chk("R1", "reset flags", int'(flags_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;

        run_vec(0, 7, 1, 0);
        chk("R1", "out_valid after op", b2i(out_valid), 1);

        // R13: idle cycle with changed data must leave outputs alone.
        begin
            int hold_r, hold_f;
            hold_r = int'(result);
            hold_f = int'(flags_out);
            @(negedge clk);
            in_valid = 1'b0; op = 5'd2; dst = 4'd3; src = 4'd9; flags_in = 6'h15;
            @(posedge clk);
            #1;
            chk("R13", "idle out_valid", b2i(out_valid), 0);
            chk("R13", "idle result held", int'(result), hold_r);
            chk("R13", "idle flags held", int'(flags_out), hold_f);
        end

        foreach (ops[k])
            for (int f = 0; f < 4; f++)
                for (int d = 0; d < MW; d++)
                    for (int s = 0; s < MW; s++)
                        run_vec(ops[k], d, s, fpat[f]);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule